// File: doc/BRIEF.md
# Load/Store Issue Timing Sequencer

This block times one single-register load, store or preload hint as it enters the load/store unit. From the addressing mode it decides whether the instruction issues in one or two cycles and which address operands have to be ready early. From the access size and the low address bits it decides whether unaligned support adds a memory access and whether it adds a cycle of result latency. It then holds the unit busy for the right number of cycles and drives one memory strobe per access cycle.

It also tracks written-back base registers. When a load or store directly follows one that wrote back the same base, the block flags that the base arrives over a local forwarding path with zero latency. A chain of writeback loads on one base therefore runs one instruction per cycle. The issue stage offers an instruction on `issue_i` together with its decoded fields, and the block accepts it in any cycle where `busy_o` is low.

Top module: `ldst_timing_seq`

## Requirements
- R1: An instruction with an immediate offset (`reg_off_i`=0), or with a positive register offset whose shift amount is 0 or is LSL by 2 (`shift_kind_i`=0 means LSL, 1 LSR, 2 ASR, 3 ROR), reports `issue_cyc_o`=1 and `early_base_o`=1. `early_off_o` equals `reg_off_i`.
- R2: A register offset that is negative, or that uses any nonzero shift other than LSL by 2, reports `issue_cyc_o`=2, `early_base_o`=0 and `early_off_o`=1.
- R3: The access size code n means 2^n bytes, and the alignment mask is 2^n-1. When `ua_en_i`=1 and either `base_lo_i` or `off_lo_i` has a bit set under that mask, the unit is occupied for one more cycle and one more memory strobe is issued. This holds even if `addr_lo_i` is aligned. When `ua_en_i`=0 there is never such an extra cycle.
- R4: For a load (`op_i`=1), `lat_vld_o`=1. `lat_o` is 3 for one-cycle issue and 4 for two-cycle issue, plus 1 when `ua_en_i`=1 and `addr_lo_i` is unaligned under the mask. For a store (`op_i`=0) or a preload (`op_i`=2), `lat_vld_o`=0 and `lat_o`=0.
- R5: An instruction is accepted at a rising edge where `issue_i`=1 and `busy_o`=0. Starting in the next cycle, `start_o` pulses for one cycle and the occupancy lasts L = issue cycles + R3 extra cycles. `mem_req_o` is high for L consecutive cycles, and `busy_o` is high in all of them but the last. The timing fields hold their values for the whole occupancy.
- R6: `base_fwd_o` pulses with `start_o` when the instruction was accepted in the last occupancy cycle of the previous instruction, that instruction had `wb_i`=1, and both instructions name the same `base_reg_i`. In every other case it stays 0.
- R7: A preload is occupied exactly like a load with the same fields. When `pld_drop_i`=1 is given with a preload, the preload issues no memory strobe, but its occupancy and `busy_o` timing are unchanged.
- R8: After reset, `busy_o`, `start_o`, `mem_req_o`, `base_fwd_o` and `lat_vld_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Instruction offered this cycle |
| op_i | input | 2 | 0 store, 1 load, 2 preload |
| reg_off_i | input | 1 | Offset comes from a register |
| off_neg_i | input | 1 | Offset is subtracted |
| shift_kind_i | input | 2 | Offset shift type, 0 = LSL |
| shift_amt_i | input | 5 | Offset shift amount |
| wb_i | input | 1 | Base register is written back |
| base_reg_i | input | 4 | Base register index |
| size_i | input | 2 | Access size code, 2^n bytes |
| base_lo_i | input | 3 | Low bits of the base value |
| off_lo_i | input | 3 | Low bits of the applied offset |
| addr_lo_i | input | 3 | Low bits of the final address |
| ua_en_i | input | 1 | Unaligned support enabled |
| pld_drop_i | input | 1 | Preload is discarded (fault, hit or abort) |
| busy_o | output | 1 | Unit occupied beyond this cycle |
| start_o | output | 1 | First cycle of an accepted instruction |
| mem_req_o | output | 1 | Memory access strobe |
| issue_cyc_o | output | 2 | Issue cycles, 1 or 2 |
| lat_vld_o | output | 1 | `lat_o` is meaningful |
| lat_o | output | 3 | Result latency of the destination |
| early_base_o | output | 1 | Base operand needed early |
| early_off_o | output | 1 | Offset register needed early |
| base_fwd_o | output | 1 | Base taken from the local forwarding path |

## Verification
A wrong occupancy count appears in the cycle after acceptance. Because `mem_req_o` and `busy_o` run for the wrong number of cycles, the error is seen before the next instruction can start. A decode or alignment error is visible at `start_o` itself, in `issue_cyc_o`, the early flags or `lat_o`. A stale forwarding record appears only on the next accepted instruction, as a wrong `base_fwd_o` pulse. The bench covers it with chained, gapped and mismatched sequences.

// File: rtl/ldst_timing_pkg.sv
package ldst_timing_pkg;
  typedef enum logic [1:0] {
    SHF_LSL = 2'd0,
    SHF_LSR = 2'd1,
    SHF_ASR = 2'd2,
    SHF_ROR = 2'd3
  } shift_kind_e;

  typedef enum logic [1:0] {
    OP_STORE = 2'd0,
    OP_LOAD  = 2'd1,
    OP_PLD   = 2'd2
  } mem_op_e;

  typedef struct packed {
    logic two_issue;
    logic early_base;
    logic early_off;
  } mode_dec_t;

  typedef struct packed {
    logic pot_ua;
    logic act_ua;
  } align_t;
endpackage

// File: rtl/ldst_mode_decode.sv
module ldst_mode_decode
  import ldst_timing_pkg::*;
#(
  parameter int SHAMT_W  = 5,
  parameter int FAST_AMT = 2
) (
  input  logic               reg_off_i,
  input  logic               off_neg_i,
  input  logic [1:0]         shift_kind_i,
  input  logic [SHAMT_W-1:0] shift_amt_i,
  output mode_dec_t          dec_o
);
  localparam logic [SHAMT_W-1:0] FastAmt = SHAMT_W'(FAST_AMT);

  logic no_shift, fast_shift, slow_mode;

  always_comb begin
    no_shift   = (shift_amt_i == '0);
    fast_shift = (shift_kind_e'(shift_kind_i) == SHF_LSL) && (shift_amt_i == FastAmt);
    slow_mode  = reg_off_i && (off_neg_i || !(no_shift || fast_shift));
    dec_o.two_issue  = slow_mode;
    dec_o.early_base = !slow_mode;
    dec_o.early_off  = reg_off_i;
  end
endmodule

// File: rtl/ldst_align_chk.sv
module ldst_align_chk
  import ldst_timing_pkg::*;
#(
  parameter int ALO_W  = 3,
  parameter int SIZE_W = 2
) (
  input  logic              ua_en_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [ALO_W-1:0]  base_lo_i,
  input  logic [ALO_W-1:0]  off_lo_i,
  input  logic [ALO_W-1:0]  addr_lo_i,
  output align_t            algn_o
);
  logic [ALO_W-1:0] mask;

  always_comb begin
    mask = ~({ALO_W{1'b1}} << size_i);
    algn_o.pot_ua = ua_en_i && (((base_lo_i & mask) != '0) || ((off_lo_i & mask) != '0));
    algn_o.act_ua = ua_en_i && ((addr_lo_i & mask) != '0);
  end
endmodule

// File: rtl/ldst_occupancy.sv
module ldst_occupancy #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             active_o,
  output logic             last_o,
  output logic             busy_o
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rem_q <= '0;
    else if (accept_i) rem_q <= len_i;
    else if (rem_q != '0) rem_q <= rem_q - 1'b1;
  end

  assign active_o = (rem_q != '0);
  assign last_o   = (rem_q == CNT_W'(1));
  assign busy_o   = active_o && !last_o;

  AST_BUSY_CONTINUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> active_o); // R5
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !accept_i) |=> (rem_q == $past(rem_q) - 1'b1)); // R5
endmodule

// File: rtl/ldst_base_fwd.sv
module ldst_base_fwd #(
  parameter int REG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             prev_last_i,
  input  logic             wb_i,
  input  logic [REG_W-1:0] base_reg_i,
  output logic             fwd_o
);
  logic             prev_wb_q;
  logic [REG_W-1:0] prev_base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_wb_q   <= 1'b0;
      prev_base_q <= '0;
      fwd_o       <= 1'b0;
    end else begin
      fwd_o <= accept_i && prev_last_i && prev_wb_q && (base_reg_i == prev_base_q);
      if (accept_i) begin
        prev_wb_q   <= wb_i;
        prev_base_q <= base_reg_i;
      end
    end
  end

  AST_FWD_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |-> $past(accept_i)); // R6
endmodule

// File: rtl/ldst_timing_seq.sv
module ldst_timing_seq
  import ldst_timing_pkg::*;
#(
  parameter int SHAMT_W  = 5,
  parameter int REG_W    = 4,
  parameter int SIZE_W   = 2,
  parameter int ALO_W    = 3,
  parameter int FAST_AMT = 2,
  parameter int BASE_LAT = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               issue_i,
  input  logic [1:0]         op_i,
  input  logic               reg_off_i,
  input  logic               off_neg_i,
  input  logic [1:0]         shift_kind_i,
  input  logic [SHAMT_W-1:0] shift_amt_i,
  input  logic               wb_i,
  input  logic [REG_W-1:0]   base_reg_i,
  input  logic [SIZE_W-1:0]  size_i,
  input  logic [ALO_W-1:0]   base_lo_i,
  input  logic [ALO_W-1:0]   off_lo_i,
  input  logic [ALO_W-1:0]   addr_lo_i,
  input  logic               ua_en_i,
  input  logic               pld_drop_i,
  output logic               busy_o,
  output logic               start_o,
  output logic               mem_req_o,
  output logic [1:0]         issue_cyc_o,
  output logic               lat_vld_o,
  output logic [2:0]         lat_o,
  output logic               early_base_o,
  output logic               early_off_o,
  output logic               base_fwd_o
);
  localparam int CNT_W = 2;
  localparam int LAT_W = 3;

  mode_dec_t        dec;
  align_t           algn;
  logic             accept, occ_active, occ_last;
  logic [CNT_W-1:0] len_d;
  logic [LAT_W-1:0] lat_d;
  logic             has_dest, drop_d;
  logic             drop_q;

  ldst_mode_decode #(.SHAMT_W(SHAMT_W), .FAST_AMT(FAST_AMT)) u_dec (
    .reg_off_i   (reg_off_i),
    .off_neg_i   (off_neg_i),
    .shift_kind_i(shift_kind_i),
    .shift_amt_i (shift_amt_i),
    .dec_o       (dec)
  );

  ldst_align_chk #(.ALO_W(ALO_W), .SIZE_W(SIZE_W)) u_algn (
    .ua_en_i  (ua_en_i),
    .size_i   (size_i),
    .base_lo_i(base_lo_i),
    .off_lo_i (off_lo_i),
    .addr_lo_i(addr_lo_i),
    .algn_o   (algn)
  );

  assign accept = issue_i && !busy_o;

  always_comb begin
    len_d    = (dec.two_issue ? CNT_W'(2) : CNT_W'(1)) + CNT_W'(algn.pot_ua);
    has_dest = (mem_op_e'(op_i) == OP_LOAD);
    lat_d    = has_dest ? (LAT_W'(BASE_LAT) + LAT_W'(dec.two_issue) + LAT_W'(algn.act_ua))
                        : '0;
    drop_d   = (mem_op_e'(op_i) == OP_PLD) && pld_drop_i;
  end

  ldst_occupancy #(.CNT_W(CNT_W)) u_occ (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .len_i   (len_d),
    .active_o(occ_active),
    .last_o  (occ_last),
    .busy_o  (busy_o)
  );

  ldst_base_fwd #(.REG_W(REG_W)) u_fwd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .prev_last_i(occ_last),
    .wb_i       (wb_i),
    .base_reg_i (base_reg_i),
    .fwd_o      (base_fwd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o      <= 1'b0;
      issue_cyc_o  <= 2'd0;
      lat_vld_o    <= 1'b0;
      lat_o        <= '0;
      early_base_o <= 1'b0;
      early_off_o  <= 1'b0;
      drop_q       <= 1'b0;
    end else begin
      start_o <= accept;
      if (accept) begin
        issue_cyc_o  <= dec.two_issue ? 2'd2 : 2'd1;
        lat_vld_o    <= has_dest;
        lat_o        <= lat_d;
        early_base_o <= dec.early_base;
        early_off_o  <= dec.early_off;
        drop_q       <= drop_d;
      end
    end
  end

  assign mem_req_o = occ_active && !drop_q;

  AST_LAT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_vld_o |-> (lat_o >= 3'd3 && lat_o <= 3'd5)); // R4
  AST_TWO_ISSUE_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && issue_cyc_o == 2'd2) |-> (!early_base_o && early_off_o)); // R2
  AST_START_IN_OCC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> occ_active); // R5
  AST_FWD_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_fwd_o |-> (start_o && $past(occ_active))); // R6
endmodule

// File: tb/ldst_timing_seq_tb_top.sv
module ldst_timing_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       issue, reg_off, off_neg, wb, ua_en, pld_drop;
  logic [1:0] op, shift_kind, size;
  logic [4:0] shift_amt;
  logic [3:0] base_reg;
  logic [2:0] base_lo, off_lo, addr_lo;
  logic       busy, start, mem_req, lat_vld, early_base, early_off, base_fwd;
  logic [1:0] issue_cyc;
  logic [2:0] lat;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  ldst_timing_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .op_i(op),
    .reg_off_i(reg_off), .off_neg_i(off_neg), .shift_kind_i(shift_kind),
    .shift_amt_i(shift_amt), .wb_i(wb), .base_reg_i(base_reg), .size_i(size),
    .base_lo_i(base_lo), .off_lo_i(off_lo), .addr_lo_i(addr_lo),
    .ua_en_i(ua_en), .pld_drop_i(pld_drop), .busy_o(busy), .start_o(start),
    .mem_req_o(mem_req), .issue_cyc_o(issue_cyc), .lat_vld_o(lat_vld),
    .lat_o(lat), .early_base_o(early_base), .early_off_o(early_off),
    .base_fwd_o(base_fwd)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_fields(input int o, input int ro, input int ng, input int sk,
                            input int sa, input int sz, input int bl, input int ol,
                            input int ue, input int dr, input int w, input int br);
    op = 2'(o); reg_off = 1'(ro); off_neg = 1'(ng); shift_kind = 2'(sk);
    shift_amt = 5'(sa); size = 2'(sz); base_lo = 3'(bl); off_lo = 3'(ol);
    addr_lo = ng != 0 ? 3'(bl - ol) : 3'(bl + ol);
    ua_en = 1'(ue); pld_drop = 1'(dr); wb = 1'(w); base_reg = 4'(br);
  endtask

  task automatic run_one(input int o, input int ro, input int ng, input int sk,
                         input int sa, input int sz, input int bl, input int ol,
                         input int ue, input int dr);
    int mask, two, pot, act, len, exp_lat, memc, busyc;
    mask = (1 << sz) - 1;
    two  = (ro != 0 && (ng != 0 || !(sa == 0 || (sk == 0 && sa == 2)))) ? 1 : 0;
    pot  = (ue != 0 && (((bl & mask) != 0) || ((ol & mask) != 0))) ? 1 : 0;
    act  = (ue != 0 && ((((ng != 0) ? (bl - ol) : (bl + ol)) & mask) != 0)) ? 1 : 0;
    len  = 1 + two + pot;
    exp_lat = (o == 1) ? 3 + two + act : 0;
    @(negedge clk);
    set_fields(o, ro, ng, sk, sa, sz, bl, ol, ue, dr, 0, 0);
    issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    chk("R5", "start", int'(start), 1);
    if (two != 0) begin
      chk("R2", "issue_cyc", int'(issue_cyc), 2);
      chk("R2", "early_base", int'(early_base), 0);
      chk("R2", "early_off", int'(early_off), 1);
    end else begin
      chk("R1", "issue_cyc", int'(issue_cyc), 1);
      chk("R1", "early_base", int'(early_base), 1);
      chk("R1", "early_off", int'(early_off), ro);
    end
    chk("R4", "lat_vld", int'(lat_vld), (o == 1) ? 1 : 0);
    chk("R4", "lat", int'(lat), exp_lat);
    memc = 0; busyc = 0;
    for (int k = 0; k < 6; k++) begin
      memc += int'(mem_req);
      busyc += int'(busy);
      if (!busy) break;
      @(negedge clk);
      chk("R5", "start_pulse", int'(start), 0);
    end
    if (o == 2 && dr != 0) chk("R7", "dropped_strobes", memc, 0);
    else chk("R3", "mem_strobes", memc, len);
    chk("R5", "busy_cycles", busyc, len - 1);
    @(negedge clk);
    chk("R5", "idle_req", int'(mem_req), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int idx;
    int sk_tab[4];
    int sa_tab[4];
    int ol_tab[4];
    sk_tab = '{0, 0, 0, 3};
    sa_tab = '{0, 2, 1, 2};
    ol_tab = '{0, 1, 2, 4};
    issue = 1'b0;
    set_fields(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R8", "busy", int'(busy), 0);
    chk("R8", "start", int'(start), 0);
    chk("R8", "mem_req", int'(mem_req), 0);
    chk("R8", "lat_vld", int'(lat_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "base_fwd", int'(base_fwd), 0);

    // sweep R1 R2 R3 R4 R5 R7
    idx = 0;
    for (int ro = 0; ro < 2; ro++)
      for (int ng = 0; ng < 2; ng++)
        for (int s = 0; s < 4; s++)
          for (int sz = 0; sz < 4; sz++)
            for (int bl = 0; bl < 4; bl++)
              for (int oi = 0; oi < 4; oi++)
                for (int ue = 0; ue < 2; ue++) begin
                  run_one(idx % 3, ro, ng, sk_tab[s], sa_tab[s], sz, bl, ol_tab[oi],
                          ue, (idx / 3) % 2);
                  idx++;
                end

    // R6: three chained writeback loads on one base, one per cycle
    @(negedge clk);
    set_fields(1, 0, 0, 0, 0, 2, 0, 4, 0, 0, 1, 5);
    issue = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6", "chain_start", int'(start), 1);
      chk("R6", "chain_fwd", int'(base_fwd), (k == 0) ? 0 : 1);
    end
    issue = 1'b0;
    @(negedge clk);
    chk("R6", "chain_end", int'(start), 0);
    // gap: same base after idle cycle is not forwarded
    issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    chk("R6", "gap_fwd", int'(base_fwd), 0);
    // back to back but different base
    issue = 1'b1; base_reg = 4'd6;
    @(negedge clk);
    issue = 1'b0;
    chk("R6", "other_base_fwd", int'(base_fwd), 0);
    // previous without writeback
    issue = 1'b1; wb = 1'b0;
    @(negedge clk);
    chk("R6", "nowb_prev_start", int'(start), 1);
    wb = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    chk("R6", "nowb_fwd", int'(base_fwd), 0);
    @(negedge clk);

    // R5: held issue of a 3-cycle access is accepted only in the last cycle
    set_fields(1, 1, 1, 0, 0, 2, 1, 0, 1, 0, 0, 3);
    issue = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R5", "held_start", int'(start), (k == 0 || k == 3) ? 1 : 0);
    end
    issue = 1'b0;
    repeat (4) @(negedge clk);

    // R3: ua disabled, misaligned base gives no extra cycle
    run_one(1, 0, 0, 0, 0, 2, 3, 0, 0, 0);
    // R4: aligned final address but misaligned parts: potential only
    run_one(1, 0, 0, 0, 0, 2, 2, 2, 1, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule